// File: doc/BRIEF.md
# Six-Phase Sequential Instruction Core

This block is a small multi-cycle processor. It runs one instruction at a time through six fixed phases: fetch, decode, execute, memory, write-back and PC update. Only then does it start the next instruction. It holds a 32-bit program counter, eight 32-bit general registers and two condition flags, zero and sign. The flags describe the result of the last arithmetic instruction.

Instruction bytes come from a byte-addressed read-only port. With `FETCH_BYTES` = 6 the port returns six consecutive bytes at once, and fetch takes one cycle. With `FETCH_BYTES` = 1 the port returns one byte, and fetch takes one cycle per instruction byte.

The core supports halt, no-op, register move, immediate load, four arithmetic operations and seven jump conditions. Any other operation code stops the core with an error indication. A read-only register peek port exposes the architectural registers for observation.

Top module: `seq_core`

## Requirements
- R1: While reset is active, and on release, the PC is 0, all eight registers are 0, both flags are clear, `halted` and `error` are low, and the core starts in the fetch phase. Because the flags are cleared, a jump-if-equal in the first program after reset falls through.
- R2: Each instruction visits the phases fetch, decode, execute, memory, write-back and PC update in that order, and `retire` is high during the PC-update phase. The memory phase performs no action. With the six-byte port, instruction timing is as follows.
  - Every instruction takes 6 cycles.
  - Registers are written only in write-back.
  - The PC is written only in PC update.

  With the one-byte port, an instruction takes (its length + 5) cycles.
- R3: Instruction encoding and fetch work as follows.
  - Byte 0 holds the operation code in bits 7:4 and the function code in bits 3:0.
  - Byte 1 holds the source specifier in bits 7:4 and the destination specifier in bits 3:0.
  - 32-bit constants are little-endian.
  - The byte at offset k of an instruction is read from address PC+k.
  - Operation codes and lengths: 0 halt (1 byte), 1 no-op (1), 2 move (2), 3 immediate load (6, constant in bytes 2 to 5), 6 arithmetic (2), 7 jump (5, destination in bytes 1 to 4).
- R4: Arithmetic (code 6) computes D op S, where D is the destination register and S the source register, and writes the result to the destination register. Function 0 is add, 1 is D minus S, 2 is AND and 3 is XOR, all modulo 2^32. The zero flag is set when the result is 0, and the sign flag takes result bit 31.
- R5: Move (code 2) copies the source register into the destination register. Immediate load (code 3) writes the constant into the destination register. Neither changes the flags.
- R6: A source specifier of 8 to F reads as 0. A destination specifier of 8 to F leaves every register unchanged.
- R7: Jump (code 7) loads the destination into the PC when its condition holds, and otherwise the PC becomes the jump's address plus 5. Jumps never change the flags. The conditions by function code are:
  - 0: always
  - 1: sign or zero
  - 2: sign and not zero
  - 3: zero
  - 4: not zero
  - 5: not sign
  - 6: neither sign nor zero
- R8: Halt (code 0) raises `halted`, leaves the PC at the halt instruction's address and freezes all state until reset. A halt never pulses `retire`.
- R9: Operation codes other than 0, 1, 2, 3, 6 and 7 are invalid, and so are arithmetic function codes above 3 and jump function codes above 6. An invalid instruction raises `error` instead of `halted`, leaves the PC at its address and freezes all state until reset.
- R10: The following program leaves DEC5DEh in register 1:
  - load 500h into register 0
  - load DECADEh into register 1
  - subtract register 0 from register 1
- R11: Both fetch widths produce identical registers, PC and stop status for any program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction byte(s) wanted |
| imem_rdata | input | 8*FETCH_BYTES | Bytes at imem_addr+k in lane k (bits 8k+7:8k) |
| peek_sel | input | 3 | Register index for the peek port |
| peek_val | output | 32 | Contents of the selected register |
| pc_o | output | 32 | Current program counter |
| retire | output | 1 | High during the PC-update phase of an instruction |
| halted | output | 1 | Core stopped on a halt instruction |
| error | output | 1 | Core stopped on an invalid instruction |

## Verification
The bench targets three groups of corner cases.

- **Arithmetic edges:** subtraction that lands exactly on zero or goes negative, and addition that wraps to zero. A core with wrong flag logic would take or skip the wrong jumps.
- **Specifier and flag edges:** specifiers 8 to F, where a careless decode would alias onto registers 0 to 7. Moves and loads placed between a compare and a jump, which a core that lets them touch the flags would get wrong.
- **Timing and stops:** the phase count per instruction under both fetch widths, where a short-cut fetch shows up as a wrong retire interval. Invalid codes at the edges of the arithmetic and jump function ranges, and the state freeze after a halt or an error.

// File: rtl/seq_core_pkg.sv
package seq_core_pkg;

  localparam int XLEN     = 32;
  localparam int MAX_ILEN = 6;

  typedef enum logic [2:0] {
    PH_FETCH, PH_DECODE, PH_EXEC, PH_MEM, PH_WB, PH_PCUP, PH_HALT, PH_FAULT
  } phase_t;

  localparam logic [3:0] OP_HALT   = 4'h0;
  localparam logic [3:0] OP_NOP    = 4'h1;
  localparam logic [3:0] OP_MOVE   = 4'h2;
  localparam logic [3:0] OP_LOADI  = 4'h3;
  localparam logic [3:0] OP_ARITH  = 4'h6;
  localparam logic [3:0] OP_BRANCH = 4'h7;

  // Instruction length in bytes; unknown codes count as one byte.
  function automatic logic [2:0] instr_len(input logic [3:0] code);
    case (code)
      OP_MOVE, OP_ARITH: return 3'd2;
      OP_BRANCH:         return 3'd5;
      OP_LOADI:          return 3'd6;
      default:           return 3'd1;
    endcase
  endfunction

  function automatic logic code_ok(input logic [3:0] code, input logic [3:0] fn);
    case (code)
      OP_HALT, OP_NOP, OP_MOVE, OP_LOADI: return 1'b1;
      OP_ARITH:  return fn <= 4'd3;
      OP_BRANCH: return fn <= 4'd6;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic writes_reg(input logic [3:0] code);
    return (code == OP_MOVE) || (code == OP_LOADI) || (code == OP_ARITH);
  endfunction

  // dst op src
  function automatic logic [XLEN-1:0] alu_op(input logic [3:0] fn,
                                             input logic [XLEN-1:0] src,
                                             input logic [XLEN-1:0] dst);
    case (fn[1:0])
      2'd0:    return dst + src;
      2'd1:    return dst - src;
      2'd2:    return dst & src;
      default: return dst ^ src;
    endcase
  endfunction

  function automatic logic cond_met(input logic [3:0] fn, input logic zf, input logic sf);
    case (fn)
      4'd0:    return 1'b1;
      4'd1:    return sf | zf;
      4'd2:    return sf & ~zf;
      4'd3:    return zf;
      4'd4:    return ~zf;
      4'd5:    return ~sf;
      4'd6:    return ~sf & ~zf;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/seq_fetch.sv
module seq_fetch
  import seq_core_pkg::*;
#(
  parameter int FETCH_BYTES = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active,
  input  logic [XLEN-1:0]          pc,
  output logic [XLEN-1:0]          addr,
  input  logic [8*FETCH_BYTES-1:0] rdata,
  output logic                     done,
  output logic [8*MAX_ILEN-1:0]    bytes_o
);

  generate
    if (FETCH_BYTES >= MAX_ILEN) begin : g_wide
      assign addr    = pc;
      assign done    = active;
      assign bytes_o = rdata[8*MAX_ILEN-1:0];
    end else begin : g_serial
      localparam int CW = $clog2(MAX_ILEN + 1);
      logic [CW-1:0]                cnt;
      logic [MAX_ILEN-1:0][7:0]     held;
      logic [2:0]                   need;

      assign addr = pc + XLEN'(cnt);
      assign need = instr_len((cnt == '0) ? rdata[7:4] : held[0][7:4]);
      assign done = active && (CW'(cnt + CW'(1)) == CW'(need));

      always_comb begin
        for (int k = 0; k < MAX_ILEN; k++)
          bytes_o[8*k +: 8] = (CW'(k) == cnt) ? rdata[7:0] : held[k];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt  <= '0;
          held <= '0;
        end else if (active && !done) begin
          held[cnt] <= rdata[7:0];
          cnt       <= cnt + CW'(1);
        end else begin
          cnt <= '0;
        end
      end
    end
  endgenerate

  // Once the instruction is complete the controller must leave fetch.
  a_r2_fetch_exit: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int NREG = 8,
  parameter int W    = 32,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rd_a_sel,
  output logic [W-1:0]  rd_a,
  input  logic [3:0]    rd_b_sel,
  output logic [W-1:0]  rd_b,
  input  logic          wr_en,
  input  logic [3:0]    wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] peek_sel,
  output logic [W-1:0]  peek
);

  logic [NREG-1:0][W-1:0] q;

  assign rd_a = (int'(rd_a_sel) < NREG) ? q[rd_a_sel[SW-1:0]] : '0;
  assign rd_b = (int'(rd_b_sel) < NREG) ? q[rd_b_sel[SW-1:0]] : '0;
  assign peek = q[peek_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (wr_en && int'(wr_sel) < NREG)
      q[wr_sel[SW-1:0]] <= wr_data;
  end

  // R6: out-of-range destination never disturbs the file.
  a_r6_high_dest_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_sel) >= NREG) |=> $stable(q));

endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_core_pkg::*;
#(
  parameter int FETCH_BYTES = 6,
  parameter int NREG        = 8,
  localparam int SW         = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [XLEN-1:0]          imem_addr,
  input  logic [8*FETCH_BYTES-1:0] imem_rdata,
  input  logic [SW-1:0]            peek_sel,
  output logic [XLEN-1:0]          peek_val,
  output logic [XLEN-1:0]          pc_o,
  output logic                     retire,
  output logic                     halted,
  output logic                     error
);

  phase_t            phase;
  logic [XLEN-1:0]   pc, valc, valp, vala, valb, vale, exec_res;
  logic [3:0]        icode, ifn, ra, rb;
  logic              zf, sf, cnd;
  logic              fetch_done;
  logic [8*MAX_ILEN-1:0] fb;
  logic [XLEN-1:0]   rd_a, rd_b;

  // Named internal events
  logic ev_halt, ev_fault, wb_fire, pc_fire;
  assign ev_halt  = fetch_done && (fb[7:4] == OP_HALT);
  assign ev_fault = fetch_done && !code_ok(fb[7:4], fb[3:0]);
  assign wb_fire  = (phase == PH_WB) && writes_reg(icode);
  assign pc_fire  = (phase == PH_PCUP);

  seq_fetch #(.FETCH_BYTES(FETCH_BYTES)) u_fetch (
    .clk(clk), .rst_n(rst_n), .active(phase == PH_FETCH), .pc(pc),
    .addr(imem_addr), .rdata(imem_rdata), .done(fetch_done), .bytes_o(fb)
  );

  seq_regfile #(.NREG(NREG), .W(XLEN)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(ra), .rd_a(rd_a), .rd_b_sel(rb), .rd_b(rd_b),
    .wr_en(wb_fire), .wr_sel(rb), .wr_data(vale),
    .peek_sel(peek_sel), .peek(peek_val)
  );

  always_comb begin
    case (icode)
      OP_ARITH: exec_res = alu_op(ifn, vala, valb);
      OP_LOADI: exec_res = valc + '0;
      OP_MOVE:  exec_res = vala + '0;
      default:  exec_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FETCH;
      pc    <= '0;
      icode <= '0; ifn <= '0; ra <= '0; rb <= '0;
      valc  <= '0; valp <= '0; vala <= '0; valb <= '0; vale <= '0;
      zf    <= 1'b0; sf <= 1'b0; cnd <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH: if (fetch_done) begin
          icode <= fb[7:4];
          ifn   <= fb[3:0];
          ra    <= fb[15:12];
          rb    <= fb[11:8];
          valc  <= (fb[7:4] == OP_BRANCH) ? fb[39:8] : fb[47:16];
          valp  <= pc + XLEN'(instr_len(fb[7:4]));
          if (ev_halt)       phase <= PH_HALT;
          else if (ev_fault) phase <= PH_FAULT;
          else               phase <= PH_DECODE;
        end
        PH_DECODE: begin
          vala  <= rd_a;
          valb  <= rd_b;
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          vale <= exec_res;
          if (icode == OP_ARITH) begin
            zf <= (exec_res == '0);
            sf <= exec_res[XLEN-1];
          end
          cnd   <= (icode == OP_BRANCH) && cond_met(ifn, zf, sf);
          phase <= PH_MEM;
        end
        PH_MEM:  phase <= PH_WB;
        PH_WB:   phase <= PH_PCUP;
        PH_PCUP: begin
          pc    <= cnd ? valc : valp;
          phase <= PH_FETCH;
        end
        default: phase <= phase;
      endcase
    end
  end

  assign pc_o   = pc;
  assign retire = pc_fire;
  assign halted = (phase == PH_HALT);
  assign error  = (phase == PH_FAULT);

  // R2: phase ordering and PC update placement
  a_r2_decode_exec: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DECODE |=> phase == PH_EXEC);
  a_r2_exec_mem: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_EXEC |=> phase == PH_MEM);
  a_r2_mem_wb: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_MEM |=> phase == PH_WB);
  a_r2_wb_pcup: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_WB |=> phase == PH_PCUP);
  a_r2_pcup_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_PCUP |=> phase == PH_FETCH);
  a_r2_pc_final_only: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_fire |=> $stable(pc));
  // R4: flags move only on an arithmetic execute
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase == PH_EXEC && icode == OP_ARITH) |=> $stable({zf, sf}));
  // R8 / R9: stop states are sticky and exclusive
  a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc));
  a_r9_fault_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && !halted && $stable(pc));

endmodule

// File: tb/sim_seq_core.sv
`timescale 1ns/1ps
module sim_seq_core;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  mem [256];
  logic [31:0] a0, a1, v0, v1, pc0, pc1;
  logic [47:0] d0;
  logic [7:0]  d1;
  logic [2:0]  peek;
  logic        ret0, ret1, h0, h1, e0, e1;

  always_comb begin
    for (int k = 0; k < 6; k++) d0[8*k +: 8] = mem[8'(a0 + 32'(k))];
  end
  assign d1 = mem[a1[7:0]];

  seq_core #(.FETCH_BYTES(6)) u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(a0), .imem_rdata(d0),
    .peek_sel(peek), .peek_val(v0), .pc_o(pc0), .retire(ret0),
    .halted(h0), .error(e0));

  seq_core #(.FETCH_BYTES(1)) u1 (
    .clk(clk), .rst_n(rst_n), .imem_addr(a1), .imem_rdata(d1),
    .peek_sel(peek), .peek_val(v1), .pc_o(pc1), .retire(ret1),
    .halted(h1), .error(e1));

  int n_chk = 0, n_err = 0, cyc = 0;
  int t0 [64], t1 [64];
  int n0 = 0, n1 = 0;
  int wp = 0;

  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n) begin
    if (ret0 && n0 < 64) begin t0[n0] = cyc; n0++; end
    if (ret1 && n1 < 64) begin t1[n1] = cyc; n1++; end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- assembler ----------------
  task automatic put(input logic [7:0] b); mem[wp[7:0]] = b; wp++; endtask
  task automatic put32(input logic [31:0] v);
    for (int k = 0; k < 4; k++) put(v[8*k +: 8]);
  endtask
  task automatic i_halt; put(8'h00); endtask
  task automatic i_nop;  put(8'h10); endtask
  task automatic i_mov(input logic [3:0] s, input logic [3:0] d);
    put(8'h20); put({s, d});
  endtask
  task automatic i_imm(input logic [3:0] d, input logic [31:0] v);
    put(8'h30); put({4'hF, d}); put32(v);
  endtask
  task automatic i_op(input logic [3:0] fn, input logic [3:0] s, input logic [3:0] d);
    put({4'h6, fn}); put({s, d});
  endtask
  task automatic i_jmp(input logic [3:0] fn, input logic [31:0] dest);
    put({4'h7, fn}); put32(dest);
  endtask

  // ---------------- reference model ----------------
  logic [31:0] mr [8];
  logic [31:0] mpc;
  logic        mzf, msf, mh, me;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a[7:0]]};
  endfunction

  task automatic model_run;
    logic [3:0]  hi, lo, sa, sd;
    logic [31:0] va, vd, res;
    logic        lt, eq, take;
    for (int i = 0; i < 8; i++) mr[i] = '0;
    mpc = 0; mzf = 0; msf = 0; mh = 0; me = 0;
    for (int s = 0; s < 400; s++) begin
      if (mh || me) break;
      hi = mem[mpc[7:0]][7:4];
      lo = mem[mpc[7:0]][3:0];
      sa = mem[8'(mpc+1)][7:4];
      sd = mem[8'(mpc+1)][3:0];
      va = sa[3] ? 32'd0 : mr[sa[2:0]];
      vd = sd[3] ? 32'd0 : mr[sd[2:0]];
      case (hi)
        4'h0: mh = 1;
        4'h1: mpc = mpc + 1;
        4'h2: begin if (!sd[3]) mr[sd[2:0]] = va; mpc = mpc + 2; end
        4'h3: begin if (!sd[3]) mr[sd[2:0]] = word_at(mpc + 2); mpc = mpc + 6; end
        4'h6: if (lo > 3) me = 1;
              else begin
                if (lo == 0) res = vd + va;
                else if (lo == 1) res = vd - va;
                else if (lo == 2) res = vd & va;
                else res = vd ^ va;
                if (!sd[3]) mr[sd[2:0]] = res;
                mzf = (res == 0); msf = res[31]; mpc = mpc + 2;
              end
        4'h7: if (lo > 6) me = 1;
              else begin
                lt = msf; eq = mzf;
                case (lo)
                  4'd0: take = 1;
                  4'd1: take = lt || eq;
                  4'd2: take = lt;
                  4'd3: take = eq;
                  4'd4: take = !eq;
                  4'd5: take = !lt;
                  default: take = !lt && !eq;
                endcase
                mpc = take ? word_at(mpc + 1) : mpc + 5;
              end
        default: me = 1;
      endcase
    end
  endtask

  // ---------------- run control ----------------
  task automatic begin_prog;
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wp = 0;
    n0 = 0; n1 = 0;
  endtask

  task automatic launch(input string req);
    bit fin;
    model_run();
    repeat (2) @(negedge clk);
    n0 = 0; n1 = 0;
    rst_n = 1'b1;
    fin = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ((h0 || e0) && (h1 || e1)) begin fin = 1; break; end
    end
    chk(req, "run finished", 32'(fin), 32'd1);
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < 8; i++) begin
      peek = 3'(i); #1;
      chk(req, $sformatf("wide r%0d", i), v0, mr[i]);
      chk(req, $sformatf("narrow r%0d", i), v1, mr[i]);
    end
    chk(req, "wide pc", pc0, mpc);
    chk(req, "narrow pc", pc1, mpc);
    chk(req, "wide halted", 32'(h0), 32'(mh));
    chk(req, "narrow halted", 32'(h1), 32'(mh));
    chk(req, "wide error", 32'(e0), 32'(me));
    chk(req, "narrow error", 32'(e1), 32'(me));
  endtask

  task automatic peek_chk(input string req, input int r, input logic [31:0] exp);
    peek = 3'(r); #1;
    chk(req, $sformatf("wide r%0d", r), v0, exp);
    chk(req, $sformatf("narrow r%0d", r), v1, exp);
  endtask

  // jump with flags from a subtraction of kind 0:zero 1:negative 2:positive
  task automatic jump_case(input int kind, input int fn);
    int res;
    bit take;
    begin_prog();
    i_imm(4'h0, (kind == 0) ? 32'd3 : (kind == 1) ? 32'd4 : 32'd2);
    i_imm(4'h1, 32'd3);
    i_op(4'h1, 4'h0, 4'h1);
    i_jmp(4'(fn), 32'd26);
    i_imm(4'h7, 32'd1);
    i_halt();
    i_imm(4'h7, 32'd2);
    i_halt();
    res = (kind == 0) ? 0 : (kind == 1) ? -1 : 1;
    case (fn)
      0: take = 1;
      1: take = res <= 0;
      2: take = res < 0;
      3: take = res == 0;
      4: take = res != 0;
      5: take = res >= 0;
      default: take = res > 0;
    endcase
    launch("R7");
    peek_chk("R7", 7, take ? 32'd2 : 32'd1);
    compare("R7");
  endtask

  function automatic logic [3:0] rnd_spec(input int hi_chance);
    if ($urandom_range(0, 99) < hi_chance) return 4'(8 + $urandom_range(0, 7));
    return 4'($urandom_range(0, 7));
  endfunction

  task automatic rand_prog;
    int n, p;
    int kind [16];
    int at [17];
    logic [31:0] v;
    logic [7:0] bad [8];
    bad = '{8'h40, 8'h50, 8'h80, 8'h90, 8'hA0, 8'hB0, 8'h64, 8'h7F};
    begin_prog();
    n = 4 + $urandom_range(0, 10);
    p = 0;
    for (int i = 0; i < n; i++) begin
      kind[i] = ($urandom_range(0, 29) == 0) ? 5 : $urandom_range(0, 4);
      at[i] = p;
      case (kind[i]) 0, 5: p += 1; 1, 3: p += 2; 2: p += 6; default: p += 5; endcase
    end
    at[n] = p;
    for (int i = 0; i < n; i++) begin
      case (kind[i])
        0: i_nop();
        1: i_mov(rnd_spec(12), rnd_spec(12));
        2: begin
             v = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 2)) : $urandom;
             i_imm(rnd_spec(10), v);
           end
        3: i_op(4'($urandom_range(0, 3)), rnd_spec(10), rnd_spec(10));
        4: i_jmp(4'($urandom_range(0, 6)), 32'(at[$urandom_range(i + 1, n)]));
        default: put(bad[$urandom_range(0, 7)]);
      endcase
    end
    i_halt();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #750000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired (R2 progress)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] a, b, e, pc_hold;
    int r_hold;
    void'($urandom(32'd20240611));
    peek = '0;
    begin_prog();
    repeat (4) @(negedge clk);

    // R1: state while in reset
    chk("R1", "pc in reset", pc0, 32'd0);
    chk("R1", "halted in reset", 32'(h0 | h1), 32'd0);
    chk("R1", "error in reset", 32'(e0 | e1), 32'd0);

    // R10 (also R3 constant byte order)
    begin_prog();
    i_imm(4'h0, 32'h500); i_imm(4'h1, 32'hDECADE); i_op(4'h1, 4'h0, 4'h1); i_halt();
    launch("R10");
    peek_chk("R10", 1, 32'h00DEC5DE);
    peek_chk("R3", 0, 32'h00000500);
    compare("R10");

    // R1: registers and flags cleared by a later reset
    begin_prog();
    i_imm(4'h0, 32'd9); i_imm(4'h1, 32'd9); i_op(4'h1, 4'h0, 4'h1); i_halt();
    launch("R1");
    begin_prog();
    #1;
    for (int i = 0; i < 8; i++) peek_chk("R1", i, 32'd0);
    chk("R1", "pc after reset", pc1, 32'd0);
    i_jmp(4'h3, 32'd12);
    i_imm(4'h7, 32'd1); i_halt();
    i_imm(4'h7, 32'd2); i_halt();
    launch("R1");
    peek_chk("R1", 7, 32'd1);

    // R2: cycles per instruction for both fetch widths
    begin_prog();
    i_nop(); i_imm(4'h2, 32'h0A0B0C0D); i_nop(); i_halt();
    launch("R2");
    chk("R2", "wide retire count", 32'(n0), 32'd3);
    chk("R2", "narrow retire count", 32'(n1), 32'd3);
    chk("R2", "wide load cycles", 32'(t0[1] - t0[0]), 32'd6);
    chk("R2", "wide nop cycles", 32'(t0[2] - t0[1]), 32'd6);
    chk("R2", "narrow load cycles", 32'(t1[1] - t1[0]), 32'd11);
    chk("R2", "narrow nop cycles", 32'(t1[2] - t1[1]), 32'd6);
    chk("R8", "pc at halt", pc0, 32'd8);

    // R8: frozen after halt
    pc_hold = pc1; r_hold = n1;
    repeat (30) @(negedge clk);
    chk("R8", "pc held", pc1, pc_hold);
    chk("R8", "no retire after halt", 32'(n1), 32'(r_hold));
    chk("R8", "still halted", 32'(h0 & h1), 32'd1);
    peek_chk("R8", 2, 32'h0A0B0C0D);

    // R4: each operation, destination op source
    a = 32'h0F0F1234; b = 32'hF00F4321;
    for (int fn = 0; fn < 4; fn++) begin
      begin_prog();
      i_imm(4'h2, a); i_imm(4'h5, b); i_op(4'(fn), 4'h2, 4'h5); i_halt();
      launch("R4");
      case (fn) 0: e = b + a; 1: e = b - a; 2: e = b & a; default: e = b ^ a; endcase
      peek_chk("R4", 5, e);
    end
    // R4: wrap to zero sets the zero flag
    begin_prog();
    i_imm(4'h0, 32'hFFFFFFFF); i_imm(4'h1, 32'd1); i_op(4'h0, 4'h0, 4'h1);
    i_jmp(4'h3, 32'd26); i_imm(4'h7, 32'd1); i_halt(); i_imm(4'h7, 32'd2); i_halt();
    launch("R4");
    peek_chk("R4", 7, 32'd2);

    // R5: move copies, move and load keep the flags
    begin_prog();
    i_imm(4'h0, 32'd7); i_imm(4'h1, 32'd7); i_op(4'h1, 4'h0, 4'h1);
    i_imm(4'h4, 32'd5); i_mov(4'h4, 4'h5);
    i_jmp(4'h3, 32'd34); i_imm(4'h7, 32'd1); i_halt(); i_imm(4'h7, 32'd2); i_halt();
    launch("R5");
    peek_chk("R5", 5, 32'd5);
    peek_chk("R5", 7, 32'd2);

    // R6: high specifiers
    begin_prog();
    i_imm(4'h2, 32'd5); i_imm(4'hF, 32'h77); i_op(4'h0, 4'hF, 4'h2);
    i_mov(4'h2, 4'h8); i_mov(4'h9, 4'h3); i_halt();
    launch("R6");
    peek_chk("R6", 2, 32'd5);
    peek_chk("R6", 3, 32'd0);
    peek_chk("R6", 0, 32'd0);
    compare("R6");

    // R7: every condition under zero, negative and positive results
    for (int kind = 0; kind < 3; kind++)
      for (int fn = 0; fn < 7; fn++) jump_case(kind, fn);

    // R9: invalid codes
    begin_prog();
    i_imm(4'h3, 32'd9); put(8'h80);
    launch("R9");
    chk("R9", "error raised", 32'(e0 & e1), 32'd1);
    chk("R9", "not halted", 32'(h0 | h1), 32'd0);
    chk("R9", "pc at bad op", pc0, 32'd6);
    repeat (20) @(negedge clk);
    chk("R9", "pc frozen", pc1, 32'd6);
    peek_chk("R9", 3, 32'd9);
    begin_prog(); put(8'h64); put(8'h01); launch("R9");
    chk("R9", "arith fn 4", 32'(e0 & e1), 32'd1);
    begin_prog(); put(8'h77); put32(32'd0); launch("R9");
    chk("R9", "jump fn 7", 32'(e0 & e1), 32'd1);
    chk("R9", "jump fn 7 pc", pc1, 32'd0);

    // R11 plus R4/R7/R9: random programs against the model
    for (int t = 0; t < 40; t++) begin
      rand_prog();
      launch("R11");
      compare("R11");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule